// File: doc/BRIEF.md
# Frame Timing and Display Mode Controller

This block keeps the frame clock of a tile-based display controller. The CPU side reports, on each clock, how many CPU cycles it has executed since the previous report. The block subtracts that count from a cycle budget for the current phase. When the budget runs out, the `frame_active` line changes level and the budget is reloaded with the length of the new phase. Any overshoot is carried into the new phase, so over many frames the timing does not drift. The line stays high for a long active phase (14394 cycles by default) and low for a short blanking phase (3791 cycles by default), and the pattern repeats.

When the line falls, the block raises one interrupt request. The request stays up until the CPU acknowledges it. An internal flag records that the interrupt for the current blanking phase has already been issued. Because of this, a line that stays low does not produce a second request. Acknowledging a pending request charges the interrupt service time, 28 cycles by default, against the frame budget.

The block also holds the display-mode latch. During blanking, an access to the mode register address sets the mode. A read, including a read through an alias of that address, selects colour-stack mode. A write selects foreground/background mode. Any access outside blanking leaves the mode unchanged. The reset input is asynchronous and active low, and its release is synchronised to the clock.

Top module: `frame_mode_ctrl`

## Requirements
- R1: After reset, `frame_active` is 1, `irq_req` is 0 and `mode_fgbg` is 0 (colour-stack mode). The budget holds the full active length.
- R2: Starting from a full active budget, `frame_active` stays high until a total of ACTIVE_LEN cycles has been reported. It falls on the clock edge that consumes the last of those cycles.
- R3: During blanking, `frame_active` stays low until the blanking budget is used up. It rises on the clock edge that consumes the last cycle and reloads the budget with ACTIVE_LEN.
- R4: When a report overshoots the budget, the excess is subtracted from the length of the next phase.
- R5: `irq_req` rises on the clock edge after `frame_active` falls. It then stays high until a clock edge at which `irq_ack` is 1.
- R6: Only one request is made per falling edge. An acknowledge while `frame_active` is still low does not lead to a new request within that blanking phase.
- R7: An `irq_ack` while `irq_req` is 1 charges SVC_CYCLES against the budget in that cycle, in addition to any reported cycles. An `irq_ack` while `irq_req` is 0 charges nothing.
- R8: While `frame_active` is 0, a read (`reg_rd`=1) of an address that matches MODE_ADDR on all bits outside ALIAS_MASK sets `mode_fgbg` to 0.
- R9: While `frame_active` is 0, a write (`reg_wr`=1) to a matching address sets `mode_fgbg` to 1. When a read and a write occur in the same cycle, the write wins.
- R10: An access while `frame_active` is 1, or an access to a non-matching address, leaves `mode_fgbg` unchanged.
- R11: A cycle with `adv_valid`=0 and no acknowledged request leaves the budget and `frame_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | A cycle count is present on `adv_cycles` |
| adv_cycles | input | ADV_W | CPU cycles executed since the last report |
| reg_addr | input | ADDR_W | Register access address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| frame_active | output | 1 | 1 during the active phase, 0 during blanking |
| irq_req | output | 1 | Interrupt request |
| mode_fgbg | output | 1 | 1 for foreground/background mode, 0 for colour-stack mode |

## Verification
The bench builds the block with ACTIVE_LEN=40, BLANK_LEN=20, SVC_CYCLES=3 and ADV_W=4. With these values, several complete frames fit into a few hundred clocks. A single 4-bit report can exceed what is left in a phase, which exercises the overshoot carry. The service charge is also visible as a shortened blanking phase. The alias is reached through ALIAS_MASK bit 14, with the access made at address 0x4021. After the directed cases, a pseudo-random stream mixes reports, acknowledges and register accesses across the phase edges.

// File: rtl/frame_mode_pkg.sv
package frame_mode_pkg;

  typedef enum logic {
    MODE_CSTACK = 1'b0,
    MODE_FGBG   = 1'b1
  } disp_mode_e;

  // Number of bits needed for a signed budget that holds the largest phase
  // length and the deepest overshoot below zero.
  function automatic int budget_width(input int longest, input int max_step);
    budget_width = $clog2(longest + max_step + 1) + 2;
  endfunction

endpackage

// File: rtl/frame_rst_sync.sv
module frame_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/frame_budget.sv
module frame_budget #(
  parameter int ACTIVE_LEN = 14394,
  parameter int BLANK_LEN  = 3791,
  parameter int SVC_CYCLES = 28,
  parameter int ADV_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [ADV_W-1:0] adv_cycles,
  input  logic             svc_charge,
  output logic             status
);

  import frame_mode_pkg::*;

  localparam int MAX_STEP = (1 << ADV_W) - 1 + SVC_CYCLES;
  localparam int LONGEST  = (ACTIVE_LEN > BLANK_LEN) ? ACTIVE_LEN : BLANK_LEN;
  localparam int CNT_W    = budget_width(LONGEST, MAX_STEP);
  localparam logic [CNT_W-1:0] ACT_L = CNT_W'(ACTIVE_LEN);
  localparam logic [CNT_W-1:0] BLK_L = CNT_W'(BLANK_LEN);
  localparam logic [CNT_W-1:0] SVC_L = CNT_W'(SVC_CYCLES);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             status_q, status_d;
  logic [CNT_W-1:0] consume;
  logic [CNT_W-1:0] diff;
  logic             expired;
  logic             upd;

  // Next-state: subtract this cycle's consumption and reload on expiry.
  always_comb begin
    consume = '0;
    if (adv_valid) begin
      consume = CNT_W'(adv_cycles);
    end
    if (svc_charge) begin
      consume = consume + SVC_L;
    end
    upd      = adv_valid | svc_charge;
    diff     = rem_q - consume;
    expired  = diff[CNT_W-1] | (diff == '0);
    status_d = status_q;
    rem_d    = rem_q;
    if (upd) begin
      if (expired) begin
        status_d = ~status_q;
        rem_d    = diff + (status_q ? BLK_L : ACT_L);
      end else begin
        rem_d    = diff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= ACT_L;
      status_q <= 1'b1;
    end else if (upd) begin
      rem_q    <= rem_d;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  AST_TOGGLE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_q) |-> $past(upd)); // R2

  AST_BUDGET_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rem_q[CNT_W-1] && rem_q != '0 && rem_q <= ACT_L)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(rem_q) && $stable(status_q))); // R11

endmodule

// File: rtl/frame_irq.sv
module frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic status,
  input  logic irq_ack,
  output logic irq,
  output logic svc_charge
);

  logic irq_q, irq_d;
  logic taken_q, taken_d;
  logic fire;

  always_comb begin
    fire    = ~status & ~taken_q;
    taken_d = taken_q;
    if (status) begin
      taken_d = 1'b0;
    end else if (fire) begin
      taken_d = 1'b1;
    end
    irq_d = irq_q;
    if (fire) begin
      irq_d = 1'b1;
    end else if (irq_ack) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      taken_q <= taken_d;
    end
  end

  assign irq        = irq_q;
  assign svc_charge = irq_q & irq_ack;

  AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |=> irq_q); // R5

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q); // R5

  AST_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(!taken_q && !status)); // R6

endmodule

// File: rtl/frame_mode_latch.sv
module frame_mode_latch #(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'h0021,
  parameter logic [ADDR_W-1:0] ALIAS_MASK = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              status,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  output logic              mode_fgbg
);

  import frame_mode_pkg::*;

  localparam logic [ADDR_W-1:0] CMP_MASK = ~ALIAS_MASK;

  disp_mode_e mode_q, mode_d;
  logic       hit;
  logic       load;

  always_comb begin
    hit    = ((reg_addr & CMP_MASK) == (MODE_ADDR & CMP_MASK));
    load   = ~status & hit & (reg_rd | reg_wr);
    mode_d = reg_wr ? MODE_FGBG : MODE_CSTACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CSTACK;
    end else if (load) begin
      mode_q <= mode_d;
    end
  end

  assign mode_fgbg = (mode_q == MODE_FGBG);

  AST_MODE_ONLY_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(!status && (reg_rd || reg_wr))); // R10

  AST_WRITE_SETS_FGBG: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && hit && reg_wr) |=> (mode_q == MODE_FGBG)); // R9

endmodule

// File: rtl/frame_mode_ctrl.sv
module frame_mode_ctrl #(
  parameter int                ACTIVE_LEN = 14394,
  parameter int                BLANK_LEN  = 3791,
  parameter int                SVC_CYCLES = 28,
  parameter int                ADV_W      = 6,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'h0021,
  parameter logic [ADDR_W-1:0] ALIAS_MASK = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_valid,
  input  logic [ADV_W-1:0]  adv_cycles,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              irq_ack,
  output logic              frame_active,
  output logic              irq_req,
  output logic              mode_fgbg
);

  logic rst_n_s;
  logic status;
  logic svc_charge;

  frame_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  frame_budget #(
    .ACTIVE_LEN (ACTIVE_LEN),
    .BLANK_LEN  (BLANK_LEN),
    .SVC_CYCLES (SVC_CYCLES),
    .ADV_W      (ADV_W)
  ) u_budget (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .adv_valid  (adv_valid),
    .adv_cycles (adv_cycles),
    .svc_charge (svc_charge),
    .status     (status)
  );

  frame_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .status     (status),
    .irq_ack    (irq_ack),
    .irq        (irq_req),
    .svc_charge (svc_charge)
  );

  frame_mode_latch #(
    .ADDR_W     (ADDR_W),
    .MODE_ADDR  (MODE_ADDR),
    .ALIAS_MASK (ALIAS_MASK)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .status    (status),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .mode_fgbg (mode_fgbg)
  );

  assign frame_active = status;

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n_s) |-> (frame_active && !irq_req && !mode_fgbg)); // R1

endmodule

// File: tb/frame_mode_ctrl_test.sv
module frame_mode_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 40;
  localparam int BLK  = 20;
  localparam int SVC  = 3;
  localparam int AW   = 4;
  localparam int DW   = 16;

  logic          clk;
  logic          rst_n;
  logic          adv_valid;
  logic [AW-1:0] adv_cycles;
  logic [DW-1:0] reg_addr;
  logic          reg_rd;
  logic          reg_wr;
  logic          irq_ack;
  logic          frame_active;
  logic          irq_req;
  logic          mode_fgbg;

  frame_mode_ctrl #(
    .ACTIVE_LEN (ACT),
    .BLANK_LEN  (BLK),
    .SVC_CYCLES (SVC),
    .ADV_W      (AW),
    .ADDR_W     (DW),
    .MODE_ADDR  (16'h0021),
    .ALIAS_MASK (16'h4000)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_valid    (adv_valid),
    .adv_cycles   (adv_cycles),
    .reg_addr     (reg_addr),
    .reg_rd       (reg_rd),
    .reg_wr       (reg_wr),
    .irq_ack      (irq_ack),
    .frame_active (frame_active),
    .irq_req      (irq_req),
    .mode_fgbg    (mode_fgbg)
  );

  typedef struct {
    logic  act;
    logic  irq;
    logic  fgbg;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Bench model state
  int   m_rem;
  logic m_act, m_irq, m_taken, m_fgbg;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic av, input int adv, input logic ack,
                      input logic rd, input logic wr, input logic [DW-1:0] addr,
                      input string tag);
    int   cons;
    logic hit;
    exp_t e;
    @(negedge clk);
    adv_valid  = av;
    adv_cycles = AW'(adv);
    irq_ack    = ack;
    reg_rd     = rd;
    reg_wr     = wr;
    reg_addr   = addr;
    cons = (av ? adv : 0) + ((ack && m_irq) ? SVC : 0);
    hit  = ((addr & 16'hBFFF) == 16'h0021);
    if (!m_act && hit && wr) m_fgbg = 1'b1;
    else if (!m_act && hit && rd) m_fgbg = 1'b0;
    if (!m_act && !m_taken) begin
      m_irq = 1'b1; m_taken = 1'b1;
    end else if (ack) begin
      m_irq = 1'b0;
    end
    if (m_act) m_taken = 1'b0;
    if (cons > 0) begin
      m_rem = m_rem - cons;
      if (m_rem <= 0) begin
        m_rem = m_rem + (m_act ? BLK : ACT);
        m_act = ~m_act;
      end
    end
    e.act = m_act; e.irq = m_irq; e.fgbg = m_fgbg; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares queued expectations after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(frame_active, e.act,  "frame_active", e.tag);
        check(irq_req,      e.irq,  "irq_req",      e.tag);
        check(mode_fgbg,    e.fgbg, "mode_fgbg",    e.tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    adv_valid = 0; adv_cycles = '0; irq_ack = 0; reg_rd = 0; reg_wr = 0; reg_addr = '0;
    rst_n = 0;
    m_rem = ACT; m_act = 1; m_irq = 0; m_taken = 0; m_fgbg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(frame_active, 1'b1, "frame_active", "R1");
    check(irq_req,      1'b0, "irq_req",      "R1");
    check(mode_fgbg,    1'b0, "mode_fgbg",    "R1");

    // R11 idle cycles change nothing; R10 access while active ignored
    for (int i = 0; i < 6; i++) step(0, 9, 0, 0, 0, 16'h0000, "R11");
    step(0, 0, 0, 0, 1, 16'h0021, "R10");
    // R2 full active budget, then fall
    for (int i = 0; i < ACT - 1; i++) step(1, 1, 0, 0, 0, 16'h0000, "R2");
    step(1, 1, 0, 0, 0, 16'h0000, "R2");
    // R5 request appears and is held
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 16'h0000, "R5");
    // R9 write selects fg/bg, R8 alias read selects colour stack
    step(0, 0, 0, 0, 1, 16'h0021, "R9");
    step(0, 0, 0, 1, 0, 16'h4021, "R8");
    step(0, 0, 0, 0, 1, 16'h0022, "R10");
    step(0, 0, 0, 1, 1, 16'h0021, "R9");
    step(0, 0, 0, 1, 0, 16'h0021, "R8");
    // R7 ack charges service cycles; R6 no re-trigger while low
    step(0, 0, 1, 0, 0, 16'h0000, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 16'h0000, "R6");
    step(0, 0, 1, 0, 0, 16'h0000, "R7");
    step(1, 15, 0, 0, 0, 16'h0000, "R3");
    step(1, 1, 0, 0, 0, 16'h0000, "R3");
    step(1, 1, 0, 0, 0, 16'h0000, "R3");
    // R4 overshoot into blanking shortens it
    step(1, 15, 0, 0, 0, 16'h0000, "R4");
    step(1, 15, 0, 0, 0, 16'h0000, "R4");
    step(1, 15, 0, 0, 0, 16'h0000, "R4");
    step(0, 0, 0, 0, 0, 16'h0000, "R5");
    step(1, 14, 0, 0, 0, 16'h0000, "R4");
    step(1, 1, 0, 0, 0, 16'h0000, "R4");
    step(0, 0, 1, 0, 0, 16'h0000, "R5");
    // Mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[4:1]), lfsr[5] & lfsr[6], lfsr[7] & lfsr[8],
           lfsr[9] & lfsr[10], {1'b0, lfsr[11], 9'd0, 5'h01} | (lfsr[12] ? 16'h0020 : 16'h0002),
           "R2/R3 mix");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule